// File: doc/BRIEF.md
# Byte FIFO with Watermark Interrupts and Transmit Length Tracking

This block is a 127-entry, 8-bit FIFO that sits between a host register port and a framing engine. It carries bytes in one direction at a time. In transmit direction the host loads bytes and the framing engine takes them. In receive direction the framing engine deposits bytes and the host removes them. An occupancy count is always visible. One interrupt output tells the host to refill or to drain. In transmit direction it fires at a programmable low level; in receive direction it fires at a programmable high level.

A transmit length is written as two bytes. Writing the second byte arms a sent-byte counter that runs independently of the occupancy count. The framing engine sees a last-byte marker and the number of valid bits in each byte, so a frame may end in a partial byte. A done flag rises once the counter reaches the programmed total.

The host side is a register-style port, so it does not stall. A host write to a full FIFO is dropped and recorded in a sticky overflow flag. A host read from an empty FIFO returns zero and records a sticky underflow flag.

The framing side uses valid/ready streams with normal back-pressure:
- On `tx_*`, a byte moves on a cycle where `tx_valid` and `tx_ready` are both high.
- While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_bits` hold.
- On `rx_*`, `rx_ready` is low while the FIFO is full, and the framing engine must hold its byte until it is accepted.

Top module: `xfer_fifo`

## Requirements
- R1: After reset the count is 0, `hr_data` is 0x00, and `tx_valid`, `tx_done`, `fifo_irq`, `ovf_flag` and `udf_flag` are all 0.
- R2: Bytes leave in the order they entered. `fill_count` equals bytes accepted minus bytes removed and never exceeds 127.
- R3: With 127 bytes held, `hw_ready` is 0. A host write (`hw_valid` in transmit direction) is dropped, the count stays 127, and `ovf_flag` is set and stays set.
- R4: In receive direction, `hr_req` on an empty FIFO returns `hr_data` = 0x00, leaves the count at 0, and sets the sticky `udf_flag`.
- R5: Storage locations run 0 to 126 and the pointers wrap from 126 back to 0. Byte order holds across the wrap, and a full 127-byte fill is possible after the wrap.
- R6: Length format:
  - The first length byte (`len_sel`=0) holds length bits 11:4.
  - The second byte (`len_sel`=1) holds length bits 3:0 in [7:4], a 3-bit valid-bit count in [3:1], and the partial-byte flag in [0].
  - Writing the second byte clears the sent counter and arms transmission.
  - The number of bytes sent is length + flag. `tx_valid` stays 0 before arming and after `tx_done` rises.
- R7: On the final byte, `tx_last` is 1. `tx_bits` equals the 3-bit field when the partial-byte flag is 1, and is 8 otherwise. The field has no effect when the flag is 0. Non-final bytes report 8.
- R8: In transmit direction, `fifo_irq` is 1 when transmission is armed and not done and the count is ≤ the low level. The low level is selected by `wm_data[1:0]`: 0→4, 1→8, 2→12, 3→16 bytes.
- R9: In receive direction, `fifo_irq` is 1 when the count is ≥ the high level. The high level is selected by `wm_data[3:2]`: 0→124, 1→120, 2→112, 3→96 bytes.
- R10: A `flush` pulse empties the FIFO and disarms transmission (`tx_done` 0). It also clears both sticky flags and the sent counter, and keeps the watermark settings.
- R11: Direction rules:
  - In receive direction, host writes are refused: `hw_ready` is 0, the count is unchanged, and no overflow is recorded.
  - In transmit direction, `hr_req` has no effect.
- R12: Stream back-pressure:
  - While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds and the count is unchanged.
  - `rx_ready` is 0 while the FIFO is full, and a held `rx_valid` does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty FIFO, disarm length, clear flags |
| dir_rx | input | 1 | 1 = receive direction, 0 = transmit direction |
| hw_valid | input | 1 | Host write strobe |
| hw_data | input | 8 | Host write byte |
| hw_ready | output | 1 | Host write would be accepted |
| hr_req | input | 1 | Host read strobe (pops in receive direction) |
| hr_data | output | 8 | Head byte, 0x00 when empty or in transmit direction |
| rx_valid | input | 1 | Framing engine has a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO accepts the received byte |
| tx_valid | output | 1 | Byte offered to the framing engine |
| tx_data | output | 8 | Byte to transmit |
| tx_last | output | 1 | Offered byte is the final byte of the frame |
| tx_bits | output | 4 | Valid bits in the offered byte |
| tx_ready | input | 1 | Framing engine takes the byte |
| tx_done | output | 1 | Sent count reached the programmed total |
| len_we | input | 1 | Length byte write strobe |
| len_sel | input | 1 | 0 = upper length byte, 1 = lower byte (arms) |
| len_data | input | 8 | Length byte value |
| wm_we | input | 1 | Watermark setting write strobe |
| wm_data | input | 4 | [3:2] high level select, [1:0] low level select |
| fill_count | output | 7 | Bytes currently held |
| fifo_irq | output | 1 | Watermark interrupt |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| udf_flag | output | 1 | Sticky empty-read flag |

## Verification
The hardest condition to reach from the ports is the pointer wrap combined with a full FIFO. It needs the write pointer to pass location 126 while the framing side has drained only part of the contents. The stimulus fills all 127 locations while no length is armed, so nothing leaves, and then attempts one more write to provoke the overflow. It then arms a short length to drain ten bytes and refills ten bytes across the wrap. Finally it arms the full 127-byte length and checks every byte that comes out in order. Watermark thresholds are approached one byte at a time so the exact count at which the interrupt changes is observed.

// File: rtl/xfer_fifo_pkg.sv
`timescale 1ns/1ps
package xfer_fifo_pkg;

  // Watermark selection fields: high level in the upper pair, low level below.
  typedef struct packed {
    logic [1:0] hi_sel;
    logic [1:0] lo_sel;
  } wm_cfg_t;

  // Bytes remaining at or below which the transmit side asks for a refill.
  function automatic int unsigned drain_level(input logic [1:0] sel);
    return 32'd4 * (32'(sel) + 32'd1);
  endfunction

  // Bytes held at or above which the receive side asks for a drain.
  function automatic int unsigned fill_level(input int unsigned depth,
                                             input logic [1:0] sel);
    return depth + 32'd1 - (32'd4 << sel);
  endfunction

endpackage

// File: rtl/xfer_fifo_store.sv
`timescale 1ns/1ps
module xfer_fifo_store #(
  parameter int unsigned DEPTH = 127,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= step(wptr_q);
      if (pop_ok)  rptr_q <= step(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/xfer_fifo_txlen.sv
`timescale 1ns/1ps
module xfer_fifo_txlen #(
  parameter int unsigned DW = 8,
  localparam int unsigned LW = DW + 4,
  localparam int unsigned SW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          len_we,
  input  logic          len_sel,
  input  logic [DW-1:0] len_data,
  input  logic          dir_rx,
  input  logic          fifo_empty,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic          tx_last,
  output logic [3:0]    tx_bits,
  output logic          tx_done,
  output logic          busy
);
  logic [DW-1:0] hi_q;
  logic [SW-1:0] total_q, sent_q;
  logic          armed_q, brk_q;
  logic [2:0]    nbits_q;
  logic          fire;

  assign fire = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      total_q <= '0;
      sent_q  <= '0;
      armed_q <= 1'b0;
      brk_q   <= 1'b0;
      nbits_q <= '0;
    end else if (clr) begin
      sent_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (len_we && !len_sel) hi_q <= len_data;
      if (len_we && len_sel) begin
        // lower byte: [7:4] length low nibble, [3:1] bit count, [0] partial flag
        total_q <= SW'({hi_q, len_data[7:4]}) + SW'(len_data[0]);
        brk_q   <= len_data[0];
        nbits_q <= len_data[3:1];
        sent_q  <= '0;
        armed_q <= 1'b1;
      end else if (fire) begin
        sent_q <= sent_q + SW'(1);
      end
    end
  end

  assign tx_done  = armed_q && (sent_q == total_q);
  assign busy     = armed_q && !tx_done;
  assign tx_valid = busy && !dir_rx && !fifo_empty;
  assign tx_last  = ((sent_q + SW'(1)) == total_q);
  assign tx_bits  = (tx_last && brk_q) ? {1'b0, nbits_q} : 4'(DW);
endmodule

// File: rtl/xfer_fifo_wmark.sv
`timescale 1ns/1ps
module xfer_fifo_wmark
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 127,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_data,
  input  logic [CW-1:0] count,
  input  logic          dir_rx,
  input  logic          tx_pending,
  output logic          irq
);
  wm_cfg_t       cfg_q;
  logic [CW-1:0] lo_lvl, hi_lvl;

  // Not touched by flush: settings survive a FIFO reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= wm_cfg_t'(cfg_data);
  end

  assign lo_lvl = CW'(drain_level(cfg_q.lo_sel));
  assign hi_lvl = CW'(fill_level(DEPTH, cfg_q.hi_sel));
  assign irq    = dir_rx ? (count >= hi_lvl) : (tx_pending && (count <= lo_lvl));
endmodule

// File: rtl/xfer_fifo.sv
`timescale 1ns/1ps
module xfer_fifo #(
  parameter int unsigned DEPTH = 127,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          dir_rx,
  input  logic          hw_valid,
  input  logic [DW-1:0] hw_data,
  output logic          hw_ready,
  input  logic          hr_req,
  output logic [DW-1:0] hr_data,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic [3:0]    tx_bits,
  input  logic          tx_ready,
  output logic          tx_done,
  input  logic          len_we,
  input  logic          len_sel,
  input  logic [DW-1:0] len_data,
  input  logic          wm_we,
  input  logic [3:0]    wm_data,
  output logic [CW-1:0] fill_count,
  output logic          fifo_irq,
  output logic          ovf_flag,
  output logic          udf_flag
);
  logic          push, pop, full, empty, busy;
  logic [DW-1:0] pdata, head;
  logic          ovf_q, udf_q;

  assign push  = dir_rx ? rx_valid : hw_valid;
  assign pdata = dir_rx ? rx_data  : hw_data;
  assign pop   = dir_rx ? hr_req   : (tx_valid && tx_ready);

  xfer_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(push), .pdata(pdata), .pop(pop),
    .head(head), .count(fill_count), .full(full), .empty(empty)
  );

  xfer_fifo_txlen #(.DW(DW)) u_txlen (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .len_we(len_we), .len_sel(len_sel), .len_data(len_data),
    .dir_rx(dir_rx), .fifo_empty(empty), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_bits(tx_bits),
    .tx_done(tx_done), .busy(busy)
  );

  xfer_fifo_wmark #(.DEPTH(DEPTH)) u_wmark (
    .clk(clk), .rst_n(rst_n), .cfg_we(wm_we), .cfg_data(wm_data),
    .count(fill_count), .dir_rx(dir_rx), .tx_pending(busy), .irq(fifo_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (flush) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (!dir_rx && hw_valid && full) ovf_q <= 1'b1;
      if (dir_rx && hr_req && empty)   udf_q <= 1'b1;
    end
  end

  assign hw_ready = !dir_rx && !full;
  assign rx_ready = dir_rx && !full;
  assign hr_data  = (dir_rx && !empty) ? head : '0;
  assign tx_data  = head;
  assign ovf_flag = ovf_q;
  assign udf_flag = udf_q;
endmodule

// File: rtl/xfer_fifo_chk.sv
`timescale 1ns/1ps
module xfer_fifo_chk #(
  parameter int unsigned DEPTH = 127,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          dir_rx,
  input logic          hw_valid,
  input logic          hw_ready,
  input logic          hr_req,
  input logic [DW-1:0] hr_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_done,
  input logic [CW-1:0] fill_count,
  input logic          ovf_flag,
  input logic          udf_flag
);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && hw_valid && fill_count == CW'(DEPTH) && !flush) |=> ovf_flag);

  // R4
  empty_read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx && hr_req && fill_count == '0 && !flush) |=> udf_flag);

  // R4
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> (hr_data == '0));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_valid);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_count == '0 && !tx_done && !ovf_flag && !udf_flag));

  // R11
  rx_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rx |-> !hw_ready);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> (!tx_valid || $stable(tx_data)));
endmodule

bind xfer_fifo xfer_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .dir_rx(dir_rx),
  .hw_valid(hw_valid), .hw_ready(hw_ready), .hr_req(hr_req), .hr_data(hr_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_done(tx_done),
  .fill_count(fill_count), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
);

// File: tb/xfer_fifo_test.sv
`timescale 1ns/1ps
module xfer_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 0, dir_rx = 0, hw_valid = 0, hr_req = 0, rx_valid = 0;
  logic       tx_ready = 0, len_we = 0, len_sel = 0, wm_we = 0;
  logic [7:0] hw_data = 0, rx_data = 0, len_data = 0;
  logic [3:0] wm_data = 0;
  logic       hw_ready, rx_ready, tx_valid, tx_last, tx_done, fifo_irq, ovf_flag, udf_flag;
  logic [7:0] hr_data, tx_data;
  logic [3:0] tx_bits;
  logic [6:0] fill_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_fifo uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dir_rx(dir_rx),
    .hw_valid(hw_valid), .hw_data(hw_data), .hw_ready(hw_ready),
    .hr_req(hr_req), .hr_data(hr_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_bits(tx_bits),
    .tx_ready(tx_ready), .tx_done(tx_done),
    .len_we(len_we), .len_sel(len_sel), .len_data(len_data),
    .wm_we(wm_we), .wm_data(wm_data),
    .fill_count(fill_count), .fifo_irq(fifo_irq),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_flush();
    flush = 1; tick(); flush = 0; #1;
  endtask

  task automatic hwrite(input logic [7:0] d);
    hw_valid = 1; hw_data = d; tick(); hw_valid = 0;
  endtask

  task automatic rxpush(input logic [7:0] d);
    rx_valid = 1; rx_data = d; tick(); rx_valid = 0;
  endtask

  task automatic set_len(input logic [11:0] n, input logic brk, input logic [2:0] bits);
    len_we = 1; len_sel = 0; len_data = n[11:4]; tick();
    len_sel = 1; len_data = {n[3:0], bits, brk}; tick();
    len_we = 0; len_sel = 0;
  endtask

  task automatic set_wm(input logic [3:0] v);
    wm_we = 1; wm_data = v; tick(); wm_we = 0;
  endtask

  task automatic take(input string req, input int exp_d, input int exp_last, input int exp_bits);
    tx_ready = 1; #1;
    check(req, "tx_valid", tx_valid, 1);
    check(req, "tx_data", tx_data, exp_d);
    check(req, "tx_last", tx_last, exp_last);
    check(req, "tx_bits", tx_bits, exp_bits);
    tick(); tx_ready = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1", "count", fill_count, 0);
    check("R1", "hr_data", hr_data, 0);
    check("R1", "tx_valid", tx_valid, 0);
    check("R1", "tx_done", tx_done, 0);
    check("R1", "irq", fifo_irq, 0);
    check("R1", "ovf", ovf_flag, 0);
    check("R1", "udf", udf_flag, 0);
  endtask

  task automatic t_order();
    dir_rx = 0; do_flush();
    for (int k = 0; k < 5; k++) hwrite(8'hA0 + 8'(k));
    #1;
    check("R2", "count after 5 writes", fill_count, 5);
    check("R6", "tx_valid before arm", tx_valid, 0);
    set_len(12'd5, 1'b0, 3'd0);
    for (int k = 0; k < 5; k++) take("R2", 'hA0 + k, (k == 4) ? 1 : 0, 8);
    #1;
    check("R6", "tx_done", tx_done, 1);
    check("R6", "tx_valid after done", tx_valid, 0);
    check("R2", "count drained", fill_count, 0);
  endtask

  task automatic t_partial();
    dir_rx = 0; do_flush();
    for (int k = 0; k < 4; k++) hwrite(8'h10 + 8'(k));
    set_len(12'd2, 1'b1, 3'd3);
    take("R7", 'h10, 0, 8);
    take("R7", 'h11, 0, 8);
    take("R7", 'h12, 1, 3);
    #1;
    check("R6", "done after len+1", tx_done, 1);
    check("R6", "extra byte kept", fill_count, 1);
    do_flush();
    for (int k = 0; k < 2; k++) hwrite(8'h30 + 8'(k));
    set_len(12'd2, 1'b0, 3'd5);
    take("R7", 'h30, 0, 8);
    take("R7", 'h31, 1, 8);
  endtask

  task automatic t_full_wrap();
    dir_rx = 0; do_flush();
    for (int k = 0; k < 127; k++) hwrite(8'(k));
    #1;
    check("R3", "count full", fill_count, 127);
    check("R3", "hw_ready full", hw_ready, 0);
    check("R3", "ovf before", ovf_flag, 0);
    hwrite(8'hEE);
    #1;
    check("R3", "count after drop", fill_count, 127);
    check("R3", "ovf set", ovf_flag, 1);
    set_len(12'd10, 1'b0, 3'd0);
    for (int k = 0; k < 10; k++) take("R5", k, (k == 9) ? 1 : 0, 8);
    for (int k = 0; k < 10; k++) hwrite(8'(200 + k));
    #1;
    check("R5", "refilled past 126", fill_count, 127);
    check("R3", "ovf sticky", ovf_flag, 1);
    set_len(12'd127, 1'b0, 3'd0);
    for (int k = 0; k < 127; k++)
      take("R5", (k < 117) ? (k + 10) : (200 + k - 117), (k == 126) ? 1 : 0, 8);
    #1;
    check("R5", "empty after wrap", fill_count, 0);
  endtask

  task automatic t_empty_read();
    dir_rx = 1; do_flush();
    hr_req = 1; #1;
    check("R4", "hr_data empty", hr_data, 0);
    tick(); hr_req = 0; #1;
    check("R4", "udf", udf_flag, 1);
    check("R4", "count", fill_count, 0);
    hw_valid = 1; hw_data = 8'h77; #1;
    check("R11", "hw_ready rx dir", hw_ready, 0);
    tick(); hw_valid = 0; #1;
    check("R11", "count rx-dir write", fill_count, 0);
    check("R11", "no ovf rx-dir write", ovf_flag, 0);
    do_flush();
    check("R10", "udf cleared", udf_flag, 0);
  endtask

  task automatic t_rx_high();
    dir_rx = 1; do_flush();
    set_wm(4'b1100);
    do_flush();
    for (int k = 0; k < 95; k++) rxpush(8'(k * 3));
    #1;
    check("R9", "irq at 95 (level 96)", fifo_irq, 0);
    rxpush(8'(95 * 3));
    #1;
    check("R10", "irq at 96 keeps setting", fifo_irq, 1);
    set_wm(4'b0000);
    #1;
    check("R9", "irq at 96 (level 124)", fifo_irq, 0);
    for (int k = 96; k < 123; k++) rxpush(8'(k * 3));
    #1;
    check("R9", "irq at 123", fifo_irq, 0);
    rxpush(8'(123 * 3));
    #1;
    check("R9", "irq at 124", fifo_irq, 1);
    for (int k = 124; k < 127; k++) rxpush(8'(k * 3));
    #1;
    check("R12", "rx_ready full", rx_ready, 0);
    rxpush(8'hFF);
    #1;
    check("R12", "count held rx", fill_count, 127);
    dir_rx = 0; hr_req = 1; tick(); hr_req = 0; #1;
    check("R11", "tx-dir read ignored", fill_count, 127);
    dir_rx = 1;
    for (int k = 0; k < 3; k++) begin
      hr_req = 1; #1;
      check("R2", "rx order", hr_data, (k * 3) & 255);
      tick(); hr_req = 0;
    end
    #1;
    check("R2", "count after reads", fill_count, 124);
  endtask

  task automatic t_low_and_hold();
    dir_rx = 0; do_flush();
    set_wm(4'b0001);
    for (int k = 0; k < 10; k++) hwrite(8'h50 + 8'(k));
    #1;
    check("R8", "irq unarmed", fifo_irq, 0);
    set_len(12'd20, 1'b0, 3'd0);
    #1;
    check("R8", "irq at 10 (level 8)", fifo_irq, 0);
    check("R12", "offered", tx_valid, 1);
    tick(); tick(); #1;
    check("R12", "data held", tx_data, 'h50);
    check("R12", "count held", fill_count, 10);
    take("R8", 'h50, 0, 8);
    take("R8", 'h51, 0, 8);
    #1;
    check("R8", "irq at 8", fifo_irq, 1);
    do_flush();
    check("R10", "count flushed", fill_count, 0);
    check("R10", "done cleared", tx_done, 0);
    check("R10", "tx_valid cleared", tx_valid, 0);
    check("R10", "irq disarmed", fifo_irq, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_order();
    t_partial();
    t_full_wrap();
    t_empty_read();
    t_rx_high();
    t_low_and_hold();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule